// File: doc/BRIEF.md
# Floating-Point Special-Value Result Resolver

This stage sits behind a simple add/subtract/multiply datapath. It takes the two operands, the operation, a number-format select, an engine-mode select and the raw result that the datapath produced. For each valid operation it sorts both operands into one of five classes: zero, denormal, normal, infinity and NaN. Where the operand classes form one of the special combinations, it replaces the arithmetic result with the correct infinity or NaN. In every other case it forwards the raw result. In both paths NaNs are made canonical and denormals are flushed to an all-zero word.

Three encodings are supported: 32-bit single precision, 16-bit brain float and 16-bit half precision. The mode input selects between a matrix-engine rule set and a vector-engine rule set. The two sets differ only on the invalid combinations, zero times infinity and the difference of two infinities. The vector set turns these into NaN, and the matrix set lets the raw result through. The result is registered, and a valid flag marks each new result one clock after the operation is presented.

Top module: `fpsv_resolver`

## Requirements
- R1: Format codes on `fmt_sel` are 0 = 32-bit single precision (sign bit 31, exponent bits 30:23, mantissa bits 22:0), 1 = brain float (sign 15, exponent 14:7, mantissa 6:0), 2 = half precision (sign 15, exponent 14:10, mantissa 9:0), and 3 behaves as code 0. Operation codes on `op_sel` are 0 = add, 1 = subtract (the sign of operand B is inverted), 2 = multiply and 3 = no operation (no override). `mode_sel` is 0 for matrix rules and 1 for vector rules. An exponent of all ones marks infinity when the mantissa is zero and NaN otherwise. An exponent of zero marks zero when the mantissa is zero and a denormal otherwise.
- R2: Every NaN on `res_out` has an all-ones exponent and an all-ones mantissa. A NaN forwarded from the raw result keeps its sign. A NaN created by an override is positive (0x7FFFFFFF, 0x7FFF, 0x7FFF).
- R3: A forwarded raw result that is a denormal appears as an all-zero word. No output is ever a denormal.
- R4: In both modes, multiplying infinity by infinity, or infinity by a normal number, gives an infinity whose sign is the XOR of the operand signs (0x7F800000/0xFF800000, 0x7F80/0xFF80, 0x7C00/0xFC00).
- R5: In both modes, an add or subtract of two infinities with equal effective signs gives an infinity of that sign. For example, +Inf plus +Inf gives +Inf, and -Inf minus +Inf gives -Inf.
- R6: In vector mode, multiplying an infinity by a zero or a denormal gives positive canonical NaN.
- R7: In vector mode, an add or subtract of two infinities with opposite effective signs gives positive canonical NaN.
- R8: In matrix mode the R6 and R7 combinations are not overridden. In both modes, any combination with a NaN operand, every other combination, and operation code 3 forward the raw result, changed only as R2 and R3 require.
- R9: `res_out` shows the result one clock edge after `valid_in` is sampled high, and `valid_out` equals `valid_in` delayed by one cycle.
- R10: While `valid_in` is low, `res_out` keeps its previous value.
- R11: In the 16-bit formats only bits 15:0 of the operands and the raw result are used, and bits above 15 of `res_out` are zero.
- R12: During reset `res_out` is zero and `valid_out` is low, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | An operation is presented this cycle |
| fmt_sel | input | 2 | Number format code |
| mode_sel | input | 1 | 0 matrix rules, 1 vector rules |
| op_sel | input | 2 | Operation code |
| opnd_a | input | DATA_W | Operand A |
| opnd_b | input | DATA_W | Operand B |
| raw_res | input | DATA_W | Result from the arithmetic datapath |
| res_out | output | DATA_W | Resolved result |
| valid_out | output | 1 | Result on res_out is new this cycle |

## Verification
The hardest cases to reach are the ones where the operand classes and the raw-result class disagree. One example is two finite operands arriving with a raw result that is a non-canonical NaN or a denormal. Another is an invalid infinity pairing in matrix mode, where the raw word must survive untouched. A datapath model would never produce these. The bench therefore drives the raw result as an independent input and builds it from its own class choice. It sweeps every sign and class of both operands against three raw-result classes, in all four format codes, both modes and all four operations. In the 16-bit formats the bench fills the upper operand bits with junk.

// File: rtl/fpsv_pkg.sv
package fpsv_pkg;

   localparam int NUM_FMT = 3;
   localparam int HALF_W  = 16;
   localparam int WIDE_W  = 32;

   typedef enum logic [1:0] {
      FMT_SGL     = 2'd0,
      FMT_BRAIN   = 2'd1,
      FMT_HALF    = 2'd2,
      FMT_SGL_ALT = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      OP_ADD  = 2'd0,
      OP_SUB  = 2'd1,
      OP_MUL  = 2'd2,
      OP_NONE = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      CLS_ZERO = 3'd0,
      CLS_SUB  = 3'd1,
      CLS_NORM = 3'd2,
      CLS_INF  = 3'd3,
      CLS_NAN  = 3'd4
   } cls_e;

   typedef enum logic [1:0] {
      ACT_PASS = 2'd0,
      ACT_INF  = 2'd1,
      ACT_NAN  = 2'd2
   } act_e;

   typedef struct packed {
      logic sign;
      cls_e cls;
   } opnd_t;

   typedef struct packed {
      act_e act;
      logic sign;
   } decision_t;

   // exponent width of format slot idx (0 single, 1 brain, 2 half)
   function automatic int exp_w(input int idx);
      case (idx)
         0:       return 8;
         1:       return 8;
         default: return 5;
      endcase
   endfunction

   // mantissa width of format slot idx
   function automatic int man_w(input int idx);
      case (idx)
         0:       return 23;
         1:       return 7;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/fpsv_classify.sv
module fpsv_classify
   import fpsv_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] word,
   output opnd_t                info
);

   localparam int W = 1 + EXP_W + MAN_W;

   if (EXP_W < 2 || MAN_W < 1) begin : g_bad_fields
      $error("fpsv_classify: field widths too small");
   end

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_ones;
   logic             exp_zero;
   logic             man_zero;

   assign exp_f    = word[W-2 -: EXP_W];
   assign man_f    = word[MAN_W-1:0];
   assign exp_ones = &exp_f;
   assign exp_zero = ~|exp_f;
   assign man_zero = ~|man_f;

   always_comb begin
      info.sign = word[W-1];
      if (exp_ones)
         info.cls = man_zero ? CLS_INF : CLS_NAN;
      else if (exp_zero)
         info.cls = man_zero ? CLS_ZERO : CLS_SUB;
      else
         info.cls = CLS_NORM;
   end

endmodule

// File: rtl/fpsv_operand_unit.sv
module fpsv_operand_unit
   import fpsv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] word,
   input  logic [1:0]        fmt_sel,
   output opnd_t             info
);

   opnd_t per_fmt [NUM_FMT];

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      localparam int EW = exp_w(g);
      localparam int MW = man_w(g);
      opnd_t cls_o;
      fpsv_classify #(.EXP_W(EW), .MAN_W(MW)) u_cls (
         .word (word[EW+MW:0]),
         .info (cls_o)
      );
      assign per_fmt[g] = cls_o;
   end

   always_comb begin
      case (fmt_e'(fmt_sel))
         FMT_BRAIN: info = per_fmt[1];
         FMT_HALF:  info = per_fmt[2];
         default:   info = per_fmt[0];
      endcase
   end

endmodule

// File: rtl/fpsv_rules.sv
module fpsv_rules
   import fpsv_pkg::*;
(
   input  logic [1:0] op_sel,
   input  logic       mode_sel,
   input  opnd_t      a_info,
   input  opnd_t      b_info,
   output decision_t  dec
);

   logic a_inf, b_inf, a_nan, b_nan, a_low, b_low, a_norm, b_norm;
   logic eff_b_sign;
   op_e  op;

   assign op     = op_e'(op_sel);
   assign a_inf  = (a_info.cls == CLS_INF);
   assign b_inf  = (b_info.cls == CLS_INF);
   assign a_nan  = (a_info.cls == CLS_NAN);
   assign b_nan  = (b_info.cls == CLS_NAN);
   assign a_low  = (a_info.cls == CLS_ZERO) || (a_info.cls == CLS_SUB);
   assign b_low  = (b_info.cls == CLS_ZERO) || (b_info.cls == CLS_SUB);
   assign a_norm = (a_info.cls == CLS_NORM);
   assign b_norm = (b_info.cls == CLS_NORM);
   assign eff_b_sign = b_info.sign ^ (op == OP_SUB);

   always_comb begin
      dec.act  = ACT_PASS;
      dec.sign = 1'b0;
      if (!(a_nan || b_nan)) begin
         case (op)
            OP_MUL: begin
               if ((a_inf && (b_inf || b_norm)) || (a_norm && b_inf)) begin
                  dec.act  = ACT_INF;
                  dec.sign = a_info.sign ^ b_info.sign;
               end else if (((a_inf && b_low) || (a_low && b_inf)) && mode_sel) begin
                  dec.act = ACT_NAN;
               end
            end
            OP_ADD, OP_SUB: begin
               if (a_inf && b_inf) begin
                  if (a_info.sign == eff_b_sign) begin
                     dec.act  = ACT_INF;
                     dec.sign = a_info.sign;
                  end else if (mode_sel) begin
                     dec.act = ACT_NAN;
                  end
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/fpsv_encode.sv
module fpsv_encode
   import fpsv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        fmt_sel,
   input  decision_t         dec,
   input  logic [DATA_W-1:0] raw,
   output logic [DATA_W-1:0] word
);

   logic [DATA_W-1:0] cand [NUM_FMT];

   for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
      localparam int EW = exp_w(g);
      localparam int MW = man_w(g);
      localparam int FW = 1 + EW + MW;
      opnd_t             raw_info;
      logic [DATA_W-1:0] cand_g;

      fpsv_classify #(.EXP_W(EW), .MAN_W(MW)) u_raw_cls (
         .word (raw[FW-1:0]),
         .info (raw_info)
      );

      always_comb begin
         cand_g = '0;
         case (dec.act)
            ACT_INF: cand_g[FW-1:0] = {dec.sign, {EW{1'b1}}, {MW{1'b0}}};
            ACT_NAN: cand_g[FW-1:0] = {dec.sign, {(FW-1){1'b1}}};
            default: begin
               case (raw_info.cls)
                  CLS_NAN: cand_g[FW-1:0] = {raw_info.sign, {(FW-1){1'b1}}};
                  CLS_SUB: cand_g = '0;
                  default: cand_g[FW-1:0] = raw[FW-1:0];
               endcase
            end
         endcase
      end

      assign cand[g] = cand_g;
   end

   always_comb begin
      case (fmt_e'(fmt_sel))
         FMT_BRAIN: word = cand[1];
         FMT_HALF:  word = cand[2];
         default:   word = cand[0];
      endcase
   end

endmodule

// File: rtl/fpsv_resolver.sv
module fpsv_resolver
   import fpsv_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_in,
   input  logic [1:0]        fmt_sel,
   input  logic              mode_sel,
   input  logic [1:0]        op_sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] raw_res,
   output logic [DATA_W-1:0] res_out,
   output logic              valid_out
);

   if (DATA_W < WIDE_W) begin : g_bad_width
      $error("fpsv_resolver: DATA_W must hold a 32-bit word");
   end

   opnd_t             a_info;
   opnd_t             b_info;
   decision_t         dec;
   logic [DATA_W-1:0] resolved;

   fpsv_operand_unit #(.DATA_W(DATA_W)) u_cls_a (
      .word    (opnd_a),
      .fmt_sel (fmt_sel),
      .info    (a_info)
   );

   fpsv_operand_unit #(.DATA_W(DATA_W)) u_cls_b (
      .word    (opnd_b),
      .fmt_sel (fmt_sel),
      .info    (b_info)
   );

   fpsv_rules u_rules (
      .op_sel   (op_sel),
      .mode_sel (mode_sel),
      .a_info   (a_info),
      .b_info   (b_info),
      .dec      (dec)
   );

   fpsv_encode #(.DATA_W(DATA_W)) u_enc (
      .fmt_sel (fmt_sel),
      .dec     (dec),
      .raw     (raw_res),
      .word    (resolved)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_out   <= '0;
         valid_out <= 1'b0;
      end else begin
         valid_out <= valid_in;
         if (valid_in)
            res_out <= resolved;
      end
   end

endmodule

// File: rtl/fpsv_resolver_chk.sv
module fpsv_resolver_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              valid_in,
   input logic [1:0]        fmt_sel,
   input logic              mode_sel,
   input logic [1:0]        op_sel,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [DATA_W-1:0] raw_res,
   input logic [DATA_W-1:0] res_out,
   input logic              valid_out
);

   // 0 other, 1 infinity, 2 non-canonical NaN, 3 denormal, 4 canonical NaN
   function automatic logic [2:0] kind(input logic [31:0] w, input logic [1:0] f);
      logic ones, ezero, mzero, mfull;
      case (f)
         2'd1: begin
            ones = &w[14:7];  ezero = ~|w[14:7];
            mzero = ~|w[6:0]; mfull = &w[6:0];
         end
         2'd2: begin
            ones = &w[14:10]; ezero = ~|w[14:10];
            mzero = ~|w[9:0]; mfull = &w[9:0];
         end
         default: begin
            ones = &w[30:23]; ezero = ~|w[30:23];
            mzero = ~|w[22:0]; mfull = &w[22:0];
         end
      endcase
      if (ones && mzero)       return 3'd1;
      if (ones && mfull)       return 3'd4;
      if (ones)                return 3'd2;
      if (ezero && !mzero)     return 3'd3;
      return 3'd0;
   endfunction

   logic [1:0] fmt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        fmt_q <= 2'd0;
      else if (valid_in) fmt_q <= fmt_sel;
   end

   logic [2:0] out_kind, a_kind, b_kind, raw_kind;
   assign out_kind = kind(res_out[31:0], fmt_q);
   assign a_kind   = kind(opnd_a[31:0], fmt_sel);
   assign b_kind   = kind(opnd_b[31:0], fmt_sel);
   assign raw_kind = kind(raw_res[31:0], fmt_sel);

   a_r2_nan_canonical: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out |-> out_kind != 3'd2);

   a_r3_no_denorm: assert property (@(posedge clk) disable iff (!rst_n)
      valid_out |-> out_kind != 3'd3);

   a_r4_mul_inf: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && op_sel == 2'd2 && a_kind == 3'd1 && b_kind == 3'd1) |=> out_kind == 3'd1);

   a_r8_matrix_no_new_nan: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_in && !mode_sel && a_kind != 3'd2 && a_kind != 3'd4 && b_kind != 3'd2 &&
       b_kind != 3'd4 && raw_kind != 3'd2 && raw_kind != 3'd4)
      |=> (out_kind != 3'd2 && out_kind != 3'd4));

   a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      valid_in |=> valid_out);

   a_r9_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> !valid_out);

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_in |=> $stable(res_out));

   a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out && (fmt_q == 2'd1 || fmt_q == 2'd2)) |-> res_out[DATA_W-1:16] == '0);

endmodule

bind fpsv_resolver fpsv_resolver_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .valid_in  (valid_in),
   .fmt_sel   (fmt_sel),
   .mode_sel  (mode_sel),
   .op_sel    (op_sel),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .raw_res   (raw_res),
   .res_out   (res_out),
   .valid_out (valid_out)
);

// File: tb/tb_fpsv_resolver.sv
module tb_fpsv_resolver;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          valid_in = 1'b0;
   logic [1:0]    fmt_sel = 2'd0;
   logic          mode_sel = 1'b0;
   logic [1:0]    op_sel = 2'd0;
   logic [DW-1:0] opnd_a = '0;
   logic [DW-1:0] opnd_b = '0;
   logic [DW-1:0] raw_res = '0;
   logic [DW-1:0] res_out;
   logic          valid_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpsv_resolver #(.DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .fmt_sel(fmt_sel),
      .mode_sel(mode_sel), .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .raw_res(raw_res), .res_out(res_out), .valid_out(valid_out)
   );

   function automatic int ew_of(input int f);
      return (f == 2) ? 5 : 8;
   endfunction

   function automatic int mw_of(input int f);
      return (f == 1) ? 7 : ((f == 2) ? 10 : 23);
   endfunction

   // classes: 0 zero, 1 denormal, 2 normal, 3 infinity, 4 NaN
   function automatic logic [31:0] build(input int f, input bit s, input int c, input bit alt);
      int ew, mw;
      logic [63:0] e, m, w;
      ew = ew_of(f);
      mw = mw_of(f);
      case (c)
         0: begin e = 64'd0; m = 64'd0; end
         1: begin e = 64'd0; m = alt ? 64'd3 : 64'd1; end
         2: begin e = 64'd1 << (ew - 1); m = 64'd5; end
         3: begin e = (64'd1 << ew) - 64'd1; m = 64'd0; end
         default: begin e = (64'd1 << ew) - 64'd1; m = alt ? 64'd2 : 64'd1; end
      endcase
      w = (64'(s) << (ew + mw)) | (e << mw) | m;
      if (f == 1 || f == 2) w = w | 64'h0000_0000_A5C3_0000;
      return w[31:0];
   endfunction

   function automatic logic [31:0] expect_word(input int f, input bit md, input int op,
         input bit as, input int ac, input bit bs, input int bc,
         input logic [31:0] raw, input bit rs, input int rc, output string tag);
      int ew, mw, fw, act;
      bit sg, eb;
      logic [63:0] w, mask;
      ew = ew_of(f); mw = mw_of(f); fw = 1 + ew + mw;
      act = 0; sg = 1'b0; tag = "R8";
      eb = bs ^ (op == 1);
      if (ac != 4 && bc != 4) begin
         if (op == 2) begin
            if ((ac == 3 && (bc == 3 || bc == 2)) || (ac == 2 && bc == 3)) begin
               act = 1; sg = as ^ bs; tag = "R4";
            end else if ((ac == 3 && bc <= 1) || (ac <= 1 && bc == 3)) begin
               if (md) begin act = 2; tag = "R6"; end
            end
         end else if (op <= 1 && ac == 3 && bc == 3) begin
            if (as == eb) begin act = 1; sg = as; tag = "R5"; end
            else if (md) begin act = 2; tag = "R7"; end
         end
      end
      mask = (64'd1 << fw) - 64'd1;
      if (act == 1)
         w = (64'(sg) << (fw - 1)) | (((64'd1 << ew) - 64'd1) << mw);
      else if (act == 2)
         w = (64'(sg) << (fw - 1)) | ((64'd1 << (fw - 1)) - 64'd1);
      else if (rc == 4) begin
         w = (64'(rs) << (fw - 1)) | ((64'd1 << (fw - 1)) - 64'd1); tag = "R2";
      end else if (rc == 1) begin
         w = 64'd0; tag = "R3";
      end else
         w = {32'd0, raw} & mask;
      return w[31:0];
   endfunction

   task automatic check(input logic [31:0] act_v, input logic [31:0] exp_v, input string tag);
      checks++;
      if (act_v !== exp_v) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
      end
   endtask

   task automatic drive(input int f, input bit md, input int op,
         input logic [31:0] a, input logic [31:0] b, input logic [31:0] r);
      valid_in = 1'b1;
      fmt_sel  = 2'(f);
      mode_sel = md;
      op_sel   = 2'(op);
      opnd_a   = a;
      opnd_b   = b;
      raw_res  = r;
   endtask

   initial begin
      string tag;
      logic [31:0] a, b, r, e, held;
      // R12: reset holds outputs at zero even with active inputs
      drive(0, 1'b1, 2, 32'h7F80_0000, 32'h7F80_0000, 32'h1234_5678);
      repeat (3) @(negedge clk);
      check(res_out, 32'd0, "R12 reset result");
      check({31'd0, valid_out}, 32'd0, "R12 reset valid");
      rst_n = 1'b1;
      valid_in = 1'b0;
      @(negedge clk);

      // R1 / stated encodings, literal expectations
      drive(0, 1'b1, 2, 32'h7F80_0000, 32'h7F80_0000, 32'h0);
      @(negedge clk); check(res_out, 32'h7F80_0000, "R1 R4 single inf*inf");
      drive(2, 1'b0, 1, 32'h0000_FC00, 32'h0000_7C00, 32'h0);
      @(negedge clk); check(res_out, 32'h0000_FC00, "R1 R5 half -inf minus +inf");
      drive(1, 1'b1, 2, 32'h0000_0000, 32'h0000_FF80, 32'h0);
      @(negedge clk); check(res_out, 32'h0000_7FFF, "R1 R6 brain zero*inf");
      drive(0, 1'b0, 0, 32'h7F80_0000, 32'hFF80_0000, 32'h3F80_0000);
      @(negedge clk); check(res_out, 32'h3F80_0000, "R1 R8 matrix inf-inf passes");
      drive(0, 1'b1, 0, 32'h7F80_0000, 32'hFF80_0000, 32'h3F80_0000);
      @(negedge clk); check(res_out, 32'h7FFF_FFFF, "R1 R7 vector inf-inf nan");

      // R10: hold while valid_in is low, inputs changing
      held = res_out;
      valid_in = 1'b0;
      opnd_a = 32'h7F80_0000; opnd_b = 32'h7F80_0000; op_sel = 2'd2; raw_res = 32'h0;
      @(negedge clk);
      check({31'd0, valid_out}, 32'd0, "R9 valid drops");
      raw_res = 32'h4000_0000;
      @(negedge clk);
      check(res_out, held, "R10 hold");

      // Sweep: formats, modes, ops, operand signs/classes, raw classes
      for (int f = 0; f < 4; f++)
         for (int md = 0; md < 2; md++)
            for (int op = 0; op < 4; op++)
               for (int ac = 0; ac < 5; ac++)
                  for (int as = 0; as < 2; as++)
                     for (int bc = 0; bc < 5; bc++)
                        for (int bs = 0; bs < 2; bs++)
                           for (int ri = 0; ri < 3; ri++) begin
                              int rc;
                              bit rs;
                              rc = (ri == 0) ? 2 : ((ri == 1) ? 4 : 1);
                              rs = bit'(as) ^ bit'(bs);
                              a = build(f, bit'(as), ac, 1'b0);
                              b = build(f, bit'(bs), bc, 1'b1);
                              r = build(f, rs, rc, 1'b1);
                              e = expect_word(f, bit'(md), op, bit'(as), ac, bit'(bs), bc,
                                              r, rs, rc, tag);
                              drive(f, bit'(md), op, a, b, r);
                              @(negedge clk);
                              check(res_out, e, tag);
                              check({31'd0, valid_out}, 32'd1, "R9 valid follows");
                              if (f == 1 || f == 2)
                                 check({16'd0, res_out[31:16]}, 32'd0, "R11 upper zero");
                           end
      valid_in = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule